// File: doc/BRIEF.md
# Automatic Idle Clock-Gating Controller

This block decides, without any software register, when the clock of one processing core may be switched off. It follows the core's activity through a small state machine with three states: idle, ready and run. A request strobe from the system bus moves the machine from idle to ready. On the next cycle it moves to run. A done strobe from the core brings it back to idle.

While the machine sits in idle, a saturating counter measures how long the core has been unused. Once the count reaches a parameterised threshold, the core clock enable falls. The enable is held in a stage that can only change while the free-running clock is low, so the derived core clock never carries a runt pulse. A new request re-opens the enable during the low phase of the same cycle in which it arrives. The core therefore sees a full clock pulse on the edge that moves the machine to ready.

The block runs on the free-running clock itself and never on the gated clock. It reports its state code and a busy flag that the surrounding logic can observe.

Top module: `idle_clk_gate_ctrl`

## Requirements
- R1: With the machine in idle, a request sampled on a rising edge moves it to ready. The state code is 2'b00 for idle, 2'b01 for ready and 2'b10 for run.
- R2: Ready always moves to run on the next rising edge. A done strobe seen in ready has no effect on this.
- R3: Run holds until a done strobe is sampled, then moves to idle. A request seen in ready or run is ignored.
- R4: The busy output is 1 in ready and run and 0 in idle.
- R5: The enable falls after IDLE_CYCLES consecutive rising edges spent in idle with no request. It then stays low, because the counter saturates. It is always 1 in ready and run.
- R6: A request that arrives while the enable is low raises the enable during the low phase of that same clock cycle, ahead of the edge that moves the machine to ready.
- R7: The gated clock output equals the free-running clock while the enable is 1 and stays 0 while it is 0. The enable changes only while the free-running clock is low.
- R8: Synchronous reset returns the machine to idle and clears the idle count. The enable is 1 from the low phase in which reset is first seen, even if the clock was gated.
- R9: A done strobe that arrives while the machine is in idle leaves the state and the busy flag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Work request strobe from the system bus |
| done_i | input | 1 | Completion strobe from the core |
| clk_en_o | output | 1 | Glitch-safe core clock enable |
| gclk_o | output | 1 | Gated core clock |
| state_o | output | 2 | Activity state code |
| busy_o | output | 1 | High in any working state |

## Verification
The bench builds the block with IDLE_CYCLES set to 3 and the latch variant selected. With that threshold, the gating edge, the saturated hold and a wake-up from the gated state all fit into a short vector table. The table also drives strobes the machine must ignore: a request in run, a done in ready and a done in idle. Directed tests then look at the gated clock during both clock phases and apply reset both from run and from the gated state.

// File: rtl/icg_pkg.sv
package icg_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'b00,
      ST_READY = 2'b01,
      ST_RUN   = 2'b10
   } act_state_t;

   localparam int unsigned STATE_W = 2;

   function automatic logic is_working(input act_state_t s);
      return (s != ST_IDLE);
   endfunction

endpackage

// File: rtl/icg_activity_fsm.sv
module icg_activity_fsm
   import icg_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       req,
   input  logic       done,
   output act_state_t state,
   output logic       working
);

   act_state_t state_q;
   act_state_t state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (req)  state_d = ST_READY;
         ST_READY:           state_d = ST_RUN;
         ST_RUN:   if (done) state_d = ST_IDLE;
         default:            state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state_q <= ST_IDLE;
      else     state_q <= state_d;
   end

   assign state   = state_q;
   assign working = is_working(state_q);

endmodule

// File: rtl/icg_idle_counter.sv
module icg_idle_counter #(
   parameter int unsigned LIMIT = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic in_idle,
   input  logic req,
   output logic at_limit
);

   localparam int unsigned CNT_W = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
   localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(LIMIT);

   if (LIMIT < 1) begin : g_bad_limit
      $error("icg_idle_counter: LIMIT must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst || !in_idle || req) cnt_q <= '0;
      else if (cnt_q != LIMIT_V)  cnt_q <= cnt_q + 1'b1;
   end

   assign at_limit = (cnt_q == LIMIT_V);

endmodule

// File: rtl/icg_enable_hold.sv
module icg_enable_hold #(
   parameter bit USE_LATCH = 1'b1
) (
   input  logic clk,
   input  logic en_d,
   output logic en_q
);

   if (USE_LATCH) begin : g_latch
      logic hold;
      always_latch begin
         if (!clk) hold = en_d;
      end
      assign en_q = hold;
   end else begin : g_negflop
      logic hold;
      always_ff @(negedge clk) hold <= en_d;
      assign en_q = hold;
   end

endmodule

// File: rtl/idle_clk_gate_ctrl.sv
module idle_clk_gate_ctrl
   import icg_pkg::*;
#(
   parameter int unsigned IDLE_CYCLES = 4,
   parameter bit          USE_LATCH   = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               req_i,
   input  logic               done_i,
   output logic               clk_en_o,
   output logic               gclk_o,
   output logic [STATE_W-1:0] state_o,
   output logic               busy_o
);

   if (IDLE_CYCLES < 1) begin : g_bad_cfg
      $error("idle_clk_gate_ctrl: IDLE_CYCLES must be at least 1");
   end

   act_state_t state;
   logic       working;
   logic       idle_full;
   logic       en_next;
   logic       en_held;

   icg_activity_fsm u_fsm (
      .clk     (clk),
      .rst     (rst),
      .req     (req_i),
      .done    (done_i),
      .state   (state),
      .working (working)
   );

   icg_idle_counter #(.LIMIT(IDLE_CYCLES)) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .in_idle  (!working),
      .req      (req_i),
      .at_limit (idle_full)
   );

   // Gate only when idle long enough and nothing is asking for work.
   assign en_next = rst | ~(~working & idle_full & ~req_i);

   icg_enable_hold #(.USE_LATCH(USE_LATCH)) u_hold (
      .clk  (clk),
      .en_d (en_next),
      .en_q (en_held)
   );

   assign clk_en_o = en_held;
   assign gclk_o   = clk & en_held;
   assign state_o  = state;
   assign busy_o   = working;

endmodule

// File: rtl/icg_ctrl_checker.sv
module icg_ctrl_checker (
   input logic       clk,
   input logic       rst,
   input logic       req_i,
   input logic       done_i,
   input logic       clk_en_o,
   input logic [1:0] state_o,
   input logic       busy_o
);

   p_idle_to_ready_r1: assert property (@(posedge clk) disable iff (rst)
      (state_o == 2'b00 && req_i) |=> (state_o == 2'b01));

   p_ready_to_run_r2: assert property (@(posedge clk) disable iff (rst)
      (state_o == 2'b01) |=> (state_o == 2'b10));

   p_run_holds_r3: assert property (@(posedge clk) disable iff (rst)
      (state_o == 2'b10 && !done_i) |=> (state_o == 2'b10));

   p_busy_flag_r4: assert property (@(posedge clk) disable iff (rst)
      busy_o == (state_o != 2'b00));

   p_gate_only_idle_r5: assert property (@(posedge clk) disable iff (rst)
      !clk_en_o |-> (state_o == 2'b00));

   p_idle_done_ignored_r9: assert property (@(posedge clk) disable iff (rst)
      (state_o == 2'b00 && !req_i) |=> (state_o == 2'b00));

   p_reset_idle_r8: assert property (@(posedge clk)
      rst |=> (state_o == 2'b00));

endmodule

bind idle_clk_gate_ctrl icg_ctrl_checker u_chk (
   .clk      (clk),
   .rst      (rst),
   .req_i    (req_i),
   .done_i   (done_i),
   .clk_en_o (clk_en_o),
   .state_o  (state_o),
   .busy_o   (busy_o)
);

// File: tb/idle_clk_gate_ctrl_test.sv
`timescale 1ns/1ps
module idle_clk_gate_ctrl_test;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       req = 1'b0;
   logic       done = 1'b0;
   logic       en;
   logic       gclk;
   logic [1:0] st;
   logic       busy;

   int errors = 0;
   int checks = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   idle_clk_gate_ctrl #(.IDLE_CYCLES(3), .USE_LATCH(1'b1)) uut (
      .clk(clk), .rst(rst), .req_i(req), .done_i(done),
      .clk_en_o(en), .gclk_o(gclk), .state_o(st), .busy_o(busy)
   );

   // {req, done, exp_state[1:0], exp_en, exp_busy}
   localparam int NV = 22;
   localparam logic [5:0] VEC [0:NV-1] = '{
      6'b00_00_1_0, // idle count 1
      6'b00_00_1_0, // count 2
      6'b00_00_0_0, // count 3 -> gated (R5)
      6'b00_00_0_0, // saturated, still gated
      6'b10_00_1_0, // request while gated restores enable (R6)
      6'b00_01_1_1, // ready (R1)
      6'b00_10_1_1, // run (R2)
      6'b10_10_1_1, // request in run ignored (R3)
      6'b01_10_1_1, // done driven
      6'b00_00_1_0, // back to idle (R3)
      6'b00_00_1_0,
      6'b00_00_1_0,
      6'b00_00_0_0, // gated again
      6'b10_00_1_0, // wake
      6'b01_01_1_1, // done in ready
      6'b00_10_1_1, // still reaches run (R2)
      6'b01_10_1_1,
      6'b01_00_1_0, // idle; done now seen in idle (R9)
      6'b00_00_1_0, // still idle (R9)
      6'b00_00_1_0,
      6'b00_00_0_0,
      6'b00_00_0_0
   };

   task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic drive(input logic r, input logic d);
      @(posedge clk); #1; req = r; done = d;
   endtask

   task automatic sample_low();
      @(negedge clk); #2;
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : main
      // R8: reset state
      repeat (3) @(posedge clk);
      sample_low();
      chk("R8 reset state", {2'b0, st}, 4'h0);
      chk("R8 reset enable", {3'b0, en}, 4'h1);
      chk("R4 reset busy", {3'b0, busy}, 4'h0);
      @(posedge clk); #1; rst = 1'b0;

      for (int i = 0; i < NV; i++) begin
         drive(VEC[i][5], VEC[i][4]);
         sample_low();
         chk($sformatf("R1 state row %0d", i), {2'b0, st}, {2'b0, VEC[i][3:2]});
         chk($sformatf("R5 enable row %0d", i), {3'b0, en}, {3'b0, VEC[i][1]});
         chk($sformatf("R4 busy row %0d", i), {3'b0, busy}, {3'b0, VEC[i][0]});
      end

      // R7: gated clock stays low during high phase while gated
      @(posedge clk); #2;
      chk("R7 gclk low while gated", {3'b0, gclk}, 4'h0);
      #1; req = 1'b1;
      #2;
      chk("R7 enable frozen in high phase", {3'b0, en}, 4'h0);
      sample_low();
      chk("R6 enable restored in low phase", {3'b0, en}, 4'h1);
      @(posedge clk); #2;
      chk("R7 gclk pulses when enabled", {3'b0, gclk}, 4'h1);
      chk("R1 ready after wake", {2'b0, st}, 4'h1);
      #1; req = 1'b0;
      sample_low();
      chk("R7 gclk low in low phase", {3'b0, gclk}, 4'h0);
      @(posedge clk); #2;
      chk("R2 run after ready", {2'b0, st}, 4'h2);

      // R8: reset from run
      #1; rst = 1'b1;
      sample_low();
      chk("R8 state held until edge", {2'b0, st}, 4'h2);
      chk("R8 enable during reset", {3'b0, en}, 4'h1);
      sample_low();
      chk("R8 reset returns to idle", {2'b0, st}, 4'h0);
      @(posedge clk); #1; rst = 1'b0;
      repeat (4) @(posedge clk);
      sample_low();
      chk("R5 gated after idle window", {3'b0, en}, 4'h0);

      // R8: reset from gated state reopens enable
      @(posedge clk); #1; rst = 1'b1;
      sample_low();
      chk("R8 reset ungates", {3'b0, en}, 4'h1);
      @(posedge clk); #1; rst = 1'b0;
      sample_low();
      chk("R8 idle count cleared", {3'b0, en}, 4'h1);

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule